// File: doc/BRIEF.md
# Calendar-Driven Port Status Sequencer

This block produces the per-port flow-control status that a downstream status framer sends back over a packet link. It walks a programmable calendar, a list of port IDs, one slot per clock cycle. For each slot it produces a 2-bit status code for the port named in that slot. The code comes from one of two sources. The first is a 256-entry user status table, which user logic writes in any order. The second is a pair of fill flags from that port's receive FIFO, one for "half full" and one for "three-quarters full". A per-port enable bit, stored in the status table, picks the source for each port.

There are two calendar tables, bank 0 and bank 1, and only one of them drives the output at a time. Software can rewrite the idle bank while the running bank keeps producing status. The select input `cal_sel` moves the sequencer to the other bank. The sequencer reads the select input, and the length of the selected bank, only in a one-cycle load gap between passes. As a result, one pass never mixes entries from the two banks.

The controller has two states. `S_LOAD` latches the bank and its length and clears the slot pointer; it always moves on to `S_POLL`. `S_POLL` emits one slot per cycle. On the last slot it returns to `S_LOAD`; on any other slot it stays in `S_POLL` and increments the pointer.

Top module: `port_status_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `stat_valid`, `stat_last` and `active_bank` are all 0.
- R2: The status table takes a write on every rising clock edge with `st_wr_en` high. The write stores `st_wr_code` and `st_wr_ext` at index `st_wr_port`. Any slot polled after that edge uses the new values.
- R3: During a pass, the slot at pointer k reports `stat_port` equal to entry k of the active calendar bank.
- R4: A polled port with enable bit 1, on an enabled link, reports a code from its user code. User code 2'b00 gives STARVING (2'b00), 2'b01 gives HUNGRY (2'b01), 2'b10 gives SATISFIED (2'b10) and 2'b11 gives STARVING.
- R5: A polled port with enable bit 0, on an enabled link, reports a code from its fill flags. `fill_3q` high gives SATISFIED. Otherwise `fill_half` high gives HUNGRY. With both flags low the code is STARVING.
- R6: When `link_en` is low at the poll edge, the reported code is STARVING, whatever the port's table entry and fill flags.
- R7: Each pass starts with one cycle in which `stat_valid` is low. Slots 0 to L-1 then follow in consecutive cycles with `stat_valid` high, where L = len_m1+1 and ranges from 1 to 256. `stat_last` is high only on slot L-1.
- R8: The sequencer reads `cal_sel`, `main_len_m1` and `shadow_len_m1` only in the load cycle. A change to any of them during a pass takes effect at the next pass. `active_bank` shows the bank in use and stays unchanged through a pass.
- R9: Writes to the inactive calendar bank leave the running pass unchanged.
- R10: `stat_code` is never 2'b11 while `stat_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and for all table writes |
| rst_n | input | 1 | Active-low synchronous reset |
| link_en | input | 1 | Link enabled; when low, every polled code is forced to STARVING |
| st_wr_en | input | 1 | Status table write strobe |
| st_wr_port | input | 8 | Status table index (port ID) |
| st_wr_code | input | 2 | User status code to store |
| st_wr_ext | input | 1 | Stored source select: 1 = user code, 0 = fill flags |
| cal_wr_en | input | 1 | Calendar write strobe |
| cal_wr_bank | input | 1 | Calendar bank to write |
| cal_wr_slot | input | 8 | Calendar slot to write |
| cal_wr_port | input | 8 | Port ID to store in that slot |
| cal_sel | input | 1 | Requested bank, read in the load cycle |
| main_len_m1 | input | 8 | Length minus one of bank 0 |
| shadow_len_m1 | input | 8 | Length minus one of bank 1 |
| fill_half | input | 256 | Per-port FIFO fill at or above one half |
| fill_3q | input | 256 | Per-port FIFO fill at or above three quarters |
| stat_valid | output | 1 | A slot result is present this cycle |
| stat_port | output | 8 | Port ID of the slot |
| stat_code | output | 2 | Status code of the slot |
| stat_last | output | 1 | This slot is the last slot of the pass |
| active_bank | output | 1 | Calendar bank in use |

## Verification
The hardest case to reach is a bank switch or length change that lands on the edge between passes. Most select changes arrive mid-pass and simply wait, so the case where the change and the load cycle coincide comes up rarely. To reach it, the stimulus toggles `cal_sel` and both lengths on random cycles over thousands of passes. Short lengths, including a length of one, make load cycles frequent. Directed runs add a length-256 pass and a switch made in the middle of a pass. During all of this, the bench keeps rewriting the idle bank and the status table.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [1:0] {
        ST_STARVING  = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_SATISFIED = 2'b10
    } flow_status_t;

    typedef enum logic [0:0] {
        S_LOAD = 1'b0,
        S_POLL = 1'b1
    } seq_state_t;
endpackage

// File: rtl/pss_status_table.sv
module pss_status_table #(
    parameter int NPORT = 256,
    localparam int PW   = $clog2(NPORT)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_port,
    input  logic [1:0]    wr_code,
    input  logic          wr_ext,
    input  logic [PW-1:0] rd_port,
    output logic [1:0]    rd_code,
    output logic          rd_ext
);
    logic [1:0] code_mem [NPORT];
    logic       ext_mem  [NPORT];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            code_mem[wr_port] <= wr_code;
            ext_mem[wr_port]  <= wr_ext;
        end
    end

    assign rd_code = code_mem[rd_port];
    assign rd_ext  = ext_mem[rd_port];
endmodule

// File: rtl/pss_calendar.sv
module pss_calendar #(
    parameter int NPORT = 256,
    parameter int DEPTH = 256,
    localparam int PW   = $clog2(NPORT),
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [SW-1:0] wr_slot,
    input  logic [PW-1:0] wr_port,
    input  logic          rd_bank,
    input  logic [SW-1:0] rd_slot,
    output logic [PW-1:0] rd_port
);
    logic [PW-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [PW-1:0] slot_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)))
                slot_mem[wr_slot] <= wr_port;
        end

        assign bank_rd[b] = slot_mem[rd_slot];
    end

    assign rd_port = bank_rd[rd_bank];
endmodule

// File: rtl/pss_encoder.sv
module pss_encoder
    import pss_pkg::*;
(
    input  logic         link_en,
    input  logic         use_ext,
    input  logic [1:0]   user_code,
    input  logic         fill_half,
    input  logic         fill_3q,
    output flow_status_t code
);
    always_comb begin
        if (!link_en) begin
            code = ST_STARVING;
        end else if (use_ext) begin
            unique case (user_code)
                2'b00:   code = ST_STARVING;
                2'b01:   code = ST_HUNGRY;
                2'b10:   code = ST_SATISFIED;
                default: code = ST_STARVING;
            endcase
        end else if (fill_3q) begin
            code = ST_SATISFIED;
        end else if (fill_half) begin
            code = ST_HUNGRY;
        end else begin
            code = ST_STARVING;
        end
    end
endmodule

// File: rtl/port_status_seq.sv
module port_status_seq
    import pss_pkg::*;
#(
    parameter int NPORT = 256,
    parameter int DEPTH = 256,
    localparam int PW   = $clog2(NPORT),
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en,
    input  logic             st_wr_en,
    input  logic [PW-1:0]    st_wr_port,
    input  logic [1:0]       st_wr_code,
    input  logic             st_wr_ext,
    input  logic             cal_wr_en,
    input  logic             cal_wr_bank,
    input  logic [SW-1:0]    cal_wr_slot,
    input  logic [PW-1:0]    cal_wr_port,
    input  logic             cal_sel,
    input  logic [SW-1:0]    main_len_m1,
    input  logic [SW-1:0]    shadow_len_m1,
    input  logic [NPORT-1:0] fill_half,
    input  logic [NPORT-1:0] fill_3q,
    output logic             stat_valid,
    output logic [PW-1:0]    stat_port,
    output logic [1:0]       stat_code,
    output logic             stat_last,
    output logic             active_bank
);
    seq_state_t    state_q;
    logic [SW-1:0] ptr_q;
    logic [SW-1:0] len_q;
    logic          bank_q;

    logic [PW-1:0] slot_port;
    logic [1:0]    user_code;
    logic          use_ext;
    flow_status_t  enc_code;
    logic          at_end;

    pss_calendar #(.NPORT(NPORT), .DEPTH(DEPTH)) u_cal (
        .clk     (clk),
        .wr_en   (cal_wr_en),
        .wr_bank (cal_wr_bank),
        .wr_slot (cal_wr_slot),
        .wr_port (cal_wr_port),
        .rd_bank (bank_q),
        .rd_slot (ptr_q),
        .rd_port (slot_port)
    );

    pss_status_table #(.NPORT(NPORT)) u_tab (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_port (st_wr_port),
        .wr_code (st_wr_code),
        .wr_ext  (st_wr_ext),
        .rd_port (slot_port),
        .rd_code (user_code),
        .rd_ext  (use_ext)
    );

    pss_encoder u_enc (
        .link_en   (link_en),
        .use_ext   (use_ext),
        .user_code (user_code),
        .fill_half (fill_half[slot_port]),
        .fill_3q   (fill_3q[slot_port]),
        .code      (enc_code)
    );

    assign at_end = (ptr_q == len_q);

    // State register: load latches bank and length, poll walks the slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_LOAD;
            ptr_q   <= '0;
            len_q   <= '0;
            bank_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_LOAD: begin
                    bank_q  <= cal_sel;
                    len_q   <= cal_sel ? shadow_len_m1 : main_len_m1;
                    ptr_q   <= '0;
                    state_q <= S_POLL;
                end
                S_POLL: begin
                    if (at_end) begin
                        state_q <= S_LOAD;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: state_q <= S_LOAD;
            endcase
        end
    end

    // Output register: one slot result per poll cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_port  <= '0;
            stat_code  <= ST_STARVING;
            stat_last  <= 1'b0;
        end else begin
            stat_valid <= (state_q == S_POLL);
            stat_port  <= slot_port;
            stat_code  <= enc_code;
            stat_last  <= (state_q == S_POLL) && at_end;
        end
    end

    assign active_bank = bank_q;

    // R10
    property code_legal_p;
        @(posedge clk) disable iff (!rst_n) stat_valid |-> (stat_code != 2'b11);
    endproperty
    code_legal_chk: assert property (code_legal_p);

    // R7
    property last_in_pass_p;
        @(posedge clk) disable iff (!rst_n) stat_last |-> stat_valid;
    endproperty
    last_in_pass_chk: assert property (last_in_pass_p);

    // R7
    property gap_after_last_p;
        @(posedge clk) disable iff (!rst_n) stat_last |=> !stat_valid;
    endproperty
    gap_after_last_chk: assert property (gap_after_last_p);

    // R8
    property bank_hold_p;
        @(posedge clk) disable iff (!rst_n)
            (stat_valid && $past(stat_valid)) |-> $stable(active_bank);
    endproperty
    bank_hold_chk: assert property (bank_hold_p);

    // R6
    property link_down_p;
        @(posedge clk) disable iff (!rst_n)
            (stat_valid && !$past(link_en)) |-> (stat_code == ST_STARVING);
    endproperty
    link_down_chk: assert property (link_down_p);
endmodule

// File: tb/port_status_seq_test.sv
`timescale 1ns/1ps
module port_status_seq_test;
    localparam int NPORT = 256;
    localparam int DEPTH = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             link_en = 1'b1;
    logic             st_wr_en = 1'b0;
    logic [7:0]       st_wr_port = '0;
    logic [1:0]       st_wr_code = '0;
    logic             st_wr_ext = 1'b0;
    logic             cal_wr_en = 1'b0;
    logic             cal_wr_bank = 1'b0;
    logic [7:0]       cal_wr_slot = '0;
    logic [7:0]       cal_wr_port = '0;
    logic             cal_sel = 1'b0;
    logic [7:0]       main_len_m1 = 8'd7;
    logic [7:0]       shadow_len_m1 = 8'd3;
    logic [NPORT-1:0] fill_half = '0;
    logic [NPORT-1:0] fill_3q = '0;
    logic             stat_valid;
    logic [7:0]       stat_port;
    logic [1:0]       stat_code;
    logic             stat_last;
    logic             active_bank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    port_status_seq #(.NPORT(NPORT), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .st_wr_en(st_wr_en), .st_wr_port(st_wr_port), .st_wr_code(st_wr_code),
        .st_wr_ext(st_wr_ext), .cal_wr_en(cal_wr_en), .cal_wr_bank(cal_wr_bank),
        .cal_wr_slot(cal_wr_slot), .cal_wr_port(cal_wr_port), .cal_sel(cal_sel),
        .main_len_m1(main_len_m1), .shadow_len_m1(shadow_len_m1),
        .fill_half(fill_half), .fill_3q(fill_3q), .stat_valid(stat_valid),
        .stat_port(stat_port), .stat_code(stat_code), .stat_last(stat_last),
        .active_bank(active_bank)
    );

    // Expected-value model built from the requirements
    logic [7:0] m_cal [2][DEPTH];
    logic [1:0] m_ucode [NPORT];
    logic       m_ext [NPORT];
    bit         m_poll = 1'b0;
    logic [7:0] m_ptr = '0, m_len = '0;
    logic       m_bank = 1'b0;
    logic       e_valid = 1'b0, e_last = 1'b0;
    logic [7:0] e_port = '0;
    logic [1:0] e_code = '0;
    logic       e_link = 1'b1, e_ext = 1'b0;

    function automatic logic [1:0] want_code(logic link, logic ext, logic [1:0] uc,
                                             logic h, logic q);
        if (!link) return 2'b00;                 // R6
        if (ext) return (uc == 2'b11) ? 2'b00 : uc; // R4
        if (q) return 2'b10;                     // R5
        if (h) return 2'b01;
        return 2'b00;
    endfunction

    always @(posedge clk) begin
        logic [7:0] p;
        if (st_wr_en) begin                      // R2
            m_ucode[st_wr_port] <= st_wr_code;
            m_ext[st_wr_port]   <= st_wr_ext;
        end
        if (cal_wr_en) m_cal[cal_wr_bank][cal_wr_slot] <= cal_wr_port;
        if (!rst_n) begin
            m_poll <= 1'b0; m_ptr <= '0; m_len <= '0; m_bank <= 1'b0;
            e_valid <= 1'b0; e_last <= 1'b0;
        end else if (!m_poll) begin
            m_bank <= cal_sel;                   // R8
            m_len  <= cal_sel ? shadow_len_m1 : main_len_m1;
            m_ptr  <= '0;
            m_poll <= 1'b1;
            e_valid <= 1'b0; e_last <= 1'b0;
        end else begin
            p = m_cal[m_bank][m_ptr];            // R3
            e_valid <= 1'b1;
            e_port  <= p;
            e_code  <= want_code(link_en, m_ext[p], m_ucode[p], fill_half[p], fill_3q[p]);
            e_link  <= link_en;
            e_ext   <= m_ext[p];
            e_last  <= (m_ptr == m_len);         // R7
            if (m_ptr == m_len) m_poll <= 1'b0;
            else m_ptr <= m_ptr + 8'd1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(stat_valid == e_valid, "R7 valid", stat_valid, e_valid);
            check(active_bank == m_bank, "R8 bank", active_bank, m_bank);
            check(stat_last == e_last, "R7 last", stat_last, e_last);
            if (e_valid) begin
                check(stat_port == e_port, "R3 port (R9 idle bank)", stat_port, e_port);
                check(stat_code != 2'b11, "R10 code", stat_code, e_code);
                if (!e_link)     check(stat_code == e_code, "R6 code", stat_code, e_code);
                else if (e_ext)  check(stat_code == e_code, "R4 code (R2)", stat_code, e_code);
                else             check(stat_code == e_code, "R5 code", stat_code, e_code);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    task automatic step(int n, bit wild);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fill_half = {8{$urandom}};
            fill_3q   = {8{$urandom}};
            st_wr_en  = ($urandom % 4) == 0;
            st_wr_port = 8'($urandom); st_wr_code = 2'($urandom); st_wr_ext = 1'($urandom);
            cal_wr_en = ($urandom % 3) == 0;
            cal_wr_bank = wild ? 1'($urandom) : ~active_bank;  // R9: idle bank
            cal_wr_slot = 8'($urandom); cal_wr_port = 8'($urandom);
            if (wild) begin
                if ($urandom % 5 == 0) cal_sel = 1'($urandom);
                if ($urandom % 7 == 0) main_len_m1 = 8'($urandom % 6);
                if ($urandom % 7 == 0) shadow_len_m1 = 8'($urandom % 6);
                link_en = ($urandom % 6) != 0;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        // Program every table entry while reset is held
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i == 3) begin
                check(!stat_valid, "R1 valid", stat_valid, 0);
                check(!stat_last, "R1 last", stat_last, 0);
                check(!active_bank, "R1 bank", active_bank, 0);
            end
            st_wr_en = 1'b1; st_wr_port = 8'(i);
            st_wr_code = 2'($urandom); st_wr_ext = 1'($urandom);
            cal_wr_en = 1'b1; cal_wr_bank = 1'b0; cal_wr_slot = 8'(i); cal_wr_port = 8'($urandom);
        end
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            st_wr_en = 1'b0;
            cal_wr_bank = 1'b1; cal_wr_slot = 8'(i); cal_wr_port = 8'($urandom);
        end
        @(negedge clk);
        cal_wr_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!stat_valid && !active_bank, "R1 first cycle", stat_valid, 0);
        step(300, 1'b0);                     // R2, R5, R9 on bank 0
        link_en = 1'b0; step(40, 1'b0);      // R6 link down
        link_en = 1'b1;
        step(3, 1'b0); cal_sel = 1'b1;       // R8 switch mid-pass
        step(60, 1'b0);
        shadow_len_m1 = 8'd0; step(40, 1'b0); // R7 length one
        main_len_m1 = 8'd255; cal_sel = 1'b0;
        step(800, 1'b0);                     // R7 length 256
        main_len_m1 = 8'd2; shadow_len_m1 = 8'd1;
        step(6000, 1'b1);                    // random mix
        link_en = 1'b1;
        step(20, 1'b0);
        finish_run();
    end
endmodule